// File: doc/BRIEF.md
# Configuration Access Address Translator

This block sits between a configuration-space requester and a local bus. A request names a bus, a device, a function, a register offset, an access size and a direction. The block drops requests addressed to devices that cannot exist. For the requests it keeps, it works out a local bus address, the configuration transaction type code and the translation target value. It then runs one local bus access and returns a single completion to the requester.

Requests to bus 0 go straight to the local register window. Requests to any other bus go to a fixed configuration window, and the target value steers them onto the link. Byte and half-word requests are carried as one aligned 32-bit access with byte strobes. Read data is shifted down and zero-extended on the way back. A read that is filtered, or whose local bus access ends with an error, completes with all ones.

Top module: `cfg_xlate_top`

## Requirements
- R1: The type code on `lb_type` is 5'h04 when the bus number is 0 or 1, and 5'h05 when the bus number is 2 or more.
- R2: A bus-0 request uses address `LCL_BASE` plus the aligned offset. Its `lb_target` is zero.
- R3: A request to any bus other than 0 uses address `WIN_BASE` plus the aligned offset, where `WIN_BASE` defaults to 32'h01F0_0000. Its `lb_target` holds the bus in bits 31:24, the device in bits 23:19 and the function in bits 18:16, with bits 15:0 zero.
- R4: The local bus address always has bits 1:0 clear. The two low offset bits are removed before the offset is added to the base.
- R5: A request to device 2 or above on bus 0, or to device 1 or above on bus 1, causes no local bus access. It completes (`cpl_valid` high) in the cycle after it is accepted.
- R6: A filtered read completes with `cpl_rdata` = 32'hFFFF_FFFF. A filtered write changes nothing on the local bus and completes with `cpl_rdata` = 0.
- R7: When a read access ends with `lb_err` high, `cpl_rdata` is 32'hFFFF_FFFF, whatever the size.
- R8: `req_size` selects the read width: 0 = byte, 1 = half-word, 2 or 3 = word. A byte read returns bus byte lane `req_off[1:0]`. A half-word read returns lanes 3:2 when `req_off[1]` is 1 and lanes 1:0 otherwise. The result is zero-extended into `cpl_rdata`.
- R9: On a write, `lb_strb` enables only the lanes chosen by the size and offset rule of R8. `lb_wdata` carries the low bytes of `req_wdata`, moved up into those lanes.
- R10: While an access is outstanding, `req_ready` is low. The access fields on the local bus stay stable until `lb_done`. `cpl_valid` is a one-cycle pulse.
- R11: After reset, `req_ready` is high and both `lb_valid` and `cpl_valid` are low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| req_valid | input | 1 | Request present; taken when `req_ready` is high |
| req_ready | output | 1 | Block idle and able to take a request |
| req_write | input | 1 | 1 = write, 0 = read |
| req_bus | input | 8 | Bus number |
| req_dev | input | 5 | Device number |
| req_func | input | 3 | Function number |
| req_off | input | 12 | Register byte offset |
| req_size | input | 2 | 0 byte, 1 half-word, 2/3 word |
| req_wdata | input | 32 | Write data, right-aligned |
| lb_valid | output | 1 | Local bus access in progress |
| lb_write | output | 1 | Local bus direction |
| lb_addr | output | 32 | Word-aligned local bus address |
| lb_type | output | 5 | Configuration type code (04 or 05) |
| lb_target | output | 32 | Translation target value |
| lb_strb | output | 4 | Byte lane enables |
| lb_wdata | output | 32 | Lane-placed write data |
| lb_done | input | 1 | Local bus access finished |
| lb_err | input | 1 | Local bus access finished with an error |
| lb_rdata | input | 32 | Local bus read data |
| cpl_valid | output | 1 | Completion pulse |
| cpl_rdata | output | 32 | Completion read data |

## Verification
Address and type generation is tried on four buses: bus 0, bus 1, bus 2 and bus 3. Bus 0 shows the direct-window path. Bus 1 against bus 2 shows where the type code changes. Bus 3, with non-zero device and function values, shows whether the target fields sit in the right bit positions. An offset with its low bits set shows that the offset is aligned.

The filter is tried on both sides of each limit: device 1 against device 2 on bus 0, device 0 against device 1 on bus 1, and device 31 on bus 2. Reads and writes of every size are tried at several lane offsets, which tells a lane selection error apart from a shift error. Reads that end in an error response are tried at byte size and at word size.

// File: rtl/cfg_xlate_pkg.sv
package cfg_xlate_pkg;
    localparam int BUS_W  = 8;
    localparam int DEV_W  = 5;
    localparam int FN_W   = 3;
    localparam int OFF_W  = 12;
    localparam int DATA_W = 32;
    localparam int ADDR_W = 32;
    localparam int TYPE_W = 5;
    localparam int LANES  = DATA_W / 8;
    localparam int LANE_W = $clog2(LANES);
    localparam int TGT_SHIFT = ADDR_W - BUS_W - DEV_W - FN_W;

    localparam logic [TYPE_W-1:0] TYPE_LOCAL_CFG = 5'h04;
    localparam logic [TYPE_W-1:0] TYPE_FWD_CFG   = 5'h05;

    typedef enum logic [1:0] {
        SZ_BYTE = 2'd0,
        SZ_HALF = 2'd1,
        SZ_WORD = 2'd2,
        SZ_WRD2 = 2'd3
    } acc_size_e;

    typedef enum logic [1:0] {
        ST_IDLE   = 2'd0,
        ST_ACCESS = 2'd1,
        ST_DONE   = 2'd2
    } xl_state_e;

    typedef struct packed {
        logic              ok;
        logic [ADDR_W-1:0] addr;
        logic [TYPE_W-1:0] ttype;
        logic [ADDR_W-1:0] target;
    } xl_dec_t;
endpackage

// File: rtl/cfg_xlate_decode.sv
module cfg_xlate_decode
    import cfg_xlate_pkg::*;
#(
    parameter logic [ADDR_W-1:0] LCL_BASE = 32'h01FF_C000,
    parameter logic [ADDR_W-1:0] WIN_BASE = 32'h01F0_0000
) (
    input  logic [BUS_W-1:0] bus,
    input  logic [DEV_W-1:0] dev,
    input  logic [FN_W-1:0]  func,
    input  logic [OFF_W-1:0] off,
    output xl_dec_t          dec
);
    logic              bus_zero;
    logic              bus_one;
    logic [ADDR_W-1:0] off_al;

    always_comb begin
        bus_zero = (bus == '0);
        bus_one  = (bus == BUS_W'(1));
        off_al   = ADDR_W'({off[OFF_W-1:LANE_W], {LANE_W{1'b0}}});

        // Slots that cannot hold a device are never reached.
        dec.ok = !((bus_zero && dev > DEV_W'(1)) || (bus_one && dev != '0));

        dec.ttype = (bus_zero || bus_one) ? TYPE_LOCAL_CFG : TYPE_FWD_CFG;

        if (bus_zero) begin
            dec.addr   = LCL_BASE + off_al;
            dec.target = '0;
        end else begin
            dec.addr   = WIN_BASE + off_al;
            dec.target = {bus, dev, func, {TGT_SHIFT{1'b0}}};
        end
    end
endmodule

// File: rtl/cfg_xlate_lanes.sv
module cfg_xlate_lanes
    import cfg_xlate_pkg::*;
(
    input  logic [LANE_W-1:0] lane,
    input  logic [1:0]        size,
    input  logic [DATA_W-1:0] wdata_in,
    input  logic [DATA_W-1:0] rdata_in,
    output logic [LANES-1:0]  strb,
    output logic [DATA_W-1:0] wdata_out,
    output logic [DATA_W-1:0] rdata_out
);
    logic [LANE_W-1:0] first;
    logic [LANE_W:0]   count;
    logic [DATA_W-1:0] mask;
    logic [DATA_W-1:0] shifted;

    always_comb begin
        unique case (acc_size_e'(size))
            SZ_BYTE: begin first = lane;                  count = 1; end
            SZ_HALF: begin first = {lane[LANE_W-1], 1'b0}; count = 2; end
            default: begin first = '0;                    count = (LANE_W+1)'(LANES); end
        endcase

        for (int i = 0; i < LANES; i++) begin
            strb[i] = (i >= int'(first)) && (i < int'(first) + int'(count));
        end

        mask      = (count == (LANE_W+1)'(LANES)) ? '1
                  : ((DATA_W'(1) << (8 * int'(count))) - DATA_W'(1));
        wdata_out = (wdata_in & mask) << (8 * int'(first));
        shifted   = rdata_in >> (8 * int'(first));
        rdata_out = shifted & mask;
    end
endmodule

// File: rtl/cfg_xlate_top.sv
module cfg_xlate_top
    import cfg_xlate_pkg::*;
#(
    parameter logic [ADDR_W-1:0] LCL_BASE = 32'h01FF_C000,
    parameter logic [ADDR_W-1:0] WIN_BASE = 32'h01F0_0000
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              req_valid,
    output logic              req_ready,
    input  logic              req_write,
    input  logic [7:0]        req_bus,
    input  logic [4:0]        req_dev,
    input  logic [2:0]        req_func,
    input  logic [11:0]       req_off,
    input  logic [1:0]        req_size,
    input  logic [31:0]       req_wdata,
    output logic              lb_valid,
    output logic              lb_write,
    output logic [31:0]       lb_addr,
    output logic [4:0]        lb_type,
    output logic [31:0]       lb_target,
    output logic [3:0]        lb_strb,
    output logic [31:0]       lb_wdata,
    input  logic              lb_done,
    input  logic              lb_err,
    input  logic [31:0]       lb_rdata,
    output logic              cpl_valid,
    output logic [31:0]       cpl_rdata
);
    typedef struct packed {
        xl_state_e         state;
        logic              write;
        logic [1:0]        size;
        logic [LANE_W-1:0] lane;
        logic [ADDR_W-1:0] addr;
        logic [TYPE_W-1:0] ttype;
        logic [ADDR_W-1:0] target;
        logic [LANES-1:0]  strb;
        logic [DATA_W-1:0] wdata;
        logic [DATA_W-1:0] rdata;
    } xl_regs_t;

    xl_regs_t r_d, r_q;
    xl_dec_t  dec;

    logic [LANE_W-1:0] ln_lane;
    logic [1:0]        ln_size;
    logic [LANES-1:0]  ln_strb;
    logic [DATA_W-1:0] ln_wdata;
    logic [DATA_W-1:0] ln_rdata;

    cfg_xlate_decode #(
        .LCL_BASE (LCL_BASE),
        .WIN_BASE (WIN_BASE)
    ) u_dec (
        .bus  (req_bus),
        .dev  (req_dev),
        .func (req_func),
        .off  (req_off),
        .dec  (dec)
    );

    assign ln_lane = (r_q.state == ST_IDLE) ? req_off[LANE_W-1:0] : r_q.lane;
    assign ln_size = (r_q.state == ST_IDLE) ? req_size : r_q.size;

    cfg_xlate_lanes u_lanes (
        .lane      (ln_lane),
        .size      (ln_size),
        .wdata_in  (req_wdata),
        .rdata_in  (lb_rdata),
        .strb      (ln_strb),
        .wdata_out (ln_wdata),
        .rdata_out (ln_rdata)
    );

    always_comb begin
        r_d = r_q;
        unique case (r_q.state)
            ST_IDLE: begin
                if (req_valid) begin
                    r_d.write  = req_write;
                    r_d.size   = req_size;
                    r_d.lane   = req_off[LANE_W-1:0];
                    r_d.addr   = dec.addr;
                    r_d.ttype  = dec.ttype;
                    r_d.target = dec.target;
                    r_d.strb   = req_write ? ln_strb : '1;
                    r_d.wdata  = req_write ? ln_wdata : '0;
                    if (dec.ok) begin
                        r_d.state = ST_ACCESS;
                    end else begin
                        r_d.state = ST_DONE;
                        r_d.rdata = req_write ? '0 : '1;
                    end
                end
            end
            ST_ACCESS: begin
                if (lb_done) begin
                    r_d.state = ST_DONE;
                    if (r_q.write)   r_d.rdata = '0;
                    else if (lb_err) r_d.rdata = '1;
                    else             r_d.rdata = ln_rdata;
                end
            end
            default: r_d.state = ST_IDLE;
        endcase
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            r_q       <= '0;
            r_q.state <= ST_IDLE;
        end else begin
            r_q <= r_d;
        end
    end

    assign req_ready = (r_q.state == ST_IDLE);
    assign lb_valid  = (r_q.state == ST_ACCESS);
    assign lb_write  = r_q.write;
    assign lb_addr   = r_q.addr;
    assign lb_type   = r_q.ttype;
    assign lb_target = r_q.target;
    assign lb_strb   = r_q.strb;
    assign lb_wdata  = r_q.wdata;
    assign cpl_valid = (r_q.state == ST_DONE);
    assign cpl_rdata = r_q.rdata;

    p_type_split_r1: assert property (@(posedge clk) disable iff (!rst_n)
        lb_valid |-> ((lb_type == TYPE_FWD_CFG) == (lb_target[31:24] > 8'd1)));

    p_addr_aligned_r4: assert property (@(posedge clk) disable iff (!rst_n)
        lb_valid |-> (lb_addr[1:0] == 2'b00));

    p_filter_no_access_r5: assert property (@(posedge clk) disable iff (!rst_n)
        (req_ready && req_valid && !dec.ok) |=> (!lb_valid && cpl_valid));

    p_err_all_ones_r7: assert property (@(posedge clk) disable iff (!rst_n)
        (lb_valid && lb_done && lb_err && !lb_write) |=> (cpl_valid && cpl_rdata == 32'hFFFF_FFFF));

    p_hold_fields_r10: assert property (@(posedge clk) disable iff (!rst_n)
        (lb_valid && !lb_done) |=> (lb_valid && $stable(lb_addr) && $stable(lb_strb) && $stable(lb_target)));

    p_cpl_pulse_r10: assert property (@(posedge clk) disable iff (!rst_n)
        cpl_valid |=> !cpl_valid);

    p_busy_not_ready_r10: assert property (@(posedge clk) disable iff (!rst_n)
        lb_valid |-> !req_ready);
endmodule

// File: tb/cfg_xlate_top_test.sv
module cfg_xlate_top_test;
    localparam time CLK_PERIOD = 10ns;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        req_valid = 1'b0;
    logic        req_ready;
    logic        req_write = 1'b0;
    logic [7:0]  req_bus = '0;
    logic [4:0]  req_dev = '0;
    logic [2:0]  req_func = '0;
    logic [11:0] req_off = '0;
    logic [1:0]  req_size = '0;
    logic [31:0] req_wdata = '0;
    logic        lb_valid;
    logic        lb_write;
    logic [31:0] lb_addr;
    logic [4:0]  lb_type;
    logic [31:0] lb_target;
    logic [3:0]  lb_strb;
    logic [31:0] lb_wdata;
    logic        lb_done = 1'b0;
    logic        lb_err = 1'b0;
    logic [31:0] lb_rdata = '0;
    logic        cpl_valid;
    logic [31:0] cpl_rdata;

    int checks = 0;
    int errors = 0;

    always #(CLK_PERIOD/2) clk = ~clk;

    cfg_xlate_top uut (
        .clk(clk), .rst_n(rst_n),
        .req_valid(req_valid), .req_ready(req_ready), .req_write(req_write),
        .req_bus(req_bus), .req_dev(req_dev), .req_func(req_func),
        .req_off(req_off), .req_size(req_size), .req_wdata(req_wdata),
        .lb_valid(lb_valid), .lb_write(lb_write), .lb_addr(lb_addr),
        .lb_type(lb_type), .lb_target(lb_target), .lb_strb(lb_strb),
        .lb_wdata(lb_wdata), .lb_done(lb_done), .lb_err(lb_err),
        .lb_rdata(lb_rdata), .cpl_valid(cpl_valid), .cpl_rdata(cpl_rdata)
    );

    task automatic chk(string tag, logic [31:0] act, logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s actual=%h expected=%h", tag, act, exp);
        end
    endtask

    // Issue one request; capture the local bus fields if an access appears.
    task automatic issue(input logic wr, input logic [7:0] b, input logic [4:0] d,
                         input logic [2:0] f, input logic [11:0] o, input logic [1:0] sz,
                         input logic [31:0] wd, input logic [31:0] rsp, input logic er,
                         output logic seen, output logic [31:0] a, output logic [4:0] ty,
                         output logic [31:0] tg, output logic [3:0] st,
                         output logic [31:0] wo, output logic [31:0] cd, output logic cv);
        @(negedge clk);
        while (!req_ready) @(negedge clk);
        req_write = wr; req_bus = b; req_dev = d; req_func = f;
        req_off = o; req_size = sz; req_wdata = wd; req_valid = 1'b1;
        @(negedge clk);
        req_valid = 1'b0;
        seen = lb_valid;
        a = lb_addr; ty = lb_type; tg = lb_target; st = lb_strb; wo = lb_wdata;
        if (seen) begin
            @(negedge clk);
            chk("R10 held addr", lb_addr, a);
            chk("R10 ready low", {31'b0, req_ready}, 32'd0);
            lb_done = 1'b1; lb_err = er; lb_rdata = rsp;
            @(negedge clk);
            lb_done = 1'b0; lb_err = 1'b0;
        end
        cv = cpl_valid;
        cd = cpl_rdata;
        @(negedge clk);
        chk("R10 cpl pulse", {31'b0, cpl_valid}, 32'd0);
    endtask

    task automatic t_reset;
        chk("R11 ready", {31'b0, req_ready}, 32'd1);
        chk("R11 lb_valid", {31'b0, lb_valid}, 32'd0);
        chk("R11 cpl_valid", {31'b0, cpl_valid}, 32'd0);
    endtask

    task automatic t_bus0;
        logic s, cv; logic [31:0] a, tg, wo, cd; logic [4:0] ty; logic [3:0] st;
        issue(1'b0, 8'd0, 5'd1, 3'd0, 12'h013, 2'd2, 32'h0, 32'h1234_5678, 1'b0,
              s, a, ty, tg, st, wo, cd, cv);
        chk("R2 access", {31'b0, s}, 32'd1);
        chk("R2 addr", a, 32'h01FF_C010);
        chk("R4 low bits", {30'b0, a[1:0]}, 32'd0);
        chk("R2 target zero", tg, 32'h0);
        chk("R1 type bus0", {27'b0, ty}, 32'h4);
        chk("R8 word read", cd, 32'h1234_5678);
    endtask

    task automatic t_bus1;
        logic s, cv; logic [31:0] a, tg, wo, cd; logic [4:0] ty; logic [3:0] st;
        issue(1'b0, 8'd1, 5'd0, 3'd2, 12'h104, 2'd0, 32'h0, 32'hA1B2_C3D4, 1'b0,
              s, a, ty, tg, st, wo, cd, cv);
        chk("R3 addr bus1", a, 32'h01F0_0104);
        chk("R3 target bus1", tg, 32'h0102_0000);
        chk("R1 type bus1", {27'b0, ty}, 32'h4);
        chk("R8 byte lane0", cd, 32'h0000_00D4);
    endtask

    task automatic t_deep;
        logic s, cv; logic [31:0] a, tg, wo, cd; logic [4:0] ty; logic [3:0] st;
        issue(1'b0, 8'd3, 5'd5, 3'd1, 12'h042, 2'd1, 32'h0, 32'hA1B2_C3D4, 1'b0,
              s, a, ty, tg, st, wo, cd, cv);
        chk("R3 addr bus3", a, 32'h01F0_0040);
        chk("R3 target fields", tg, 32'h0329_0000);
        chk("R1 type bus3", {27'b0, ty}, 32'h5);
        chk("R8 half upper", cd, 32'h0000_A1B2);
        issue(1'b0, 8'd2, 5'd31, 3'd7, 12'h001, 2'd0, 32'h0, 32'hA1B2_C3D4, 1'b0,
              s, a, ty, tg, st, wo, cd, cv);
        chk("R5 bus2 dev31 allowed", {31'b0, s}, 32'd1);
        chk("R1 type bus2", {27'b0, ty}, 32'h5);
        chk("R8 byte lane1", cd, 32'h0000_00C3);
    endtask

    task automatic t_filter;
        logic s, cv; logic [31:0] a, tg, wo, cd; logic [4:0] ty; logic [3:0] st;
        issue(1'b0, 8'd0, 5'd2, 3'd0, 12'h000, 2'd2, 32'h0, 32'h0, 1'b0,
              s, a, ty, tg, st, wo, cd, cv);
        chk("R5 bus0 dev2 no access", {31'b0, s}, 32'd0);
        chk("R5 bus0 dev2 completes", {31'b0, cv}, 32'd1);
        chk("R6 filtered read ones", cd, 32'hFFFF_FFFF);
        issue(1'b1, 8'd1, 5'd1, 3'd0, 12'h000, 2'd2, 32'hDEAD_BEEF, 32'h0, 1'b0,
              s, a, ty, tg, st, wo, cd, cv);
        chk("R6 filtered write dropped", {31'b0, s}, 32'd0);
        chk("R6 filtered write completes", {31'b0, cv}, 32'd1);
        chk("R6 filtered write data", cd, 32'h0);
    endtask

    task automatic t_error;
        logic s, cv; logic [31:0] a, tg, wo, cd; logic [4:0] ty; logic [3:0] st;
        issue(1'b0, 8'd1, 5'd0, 3'd0, 12'h003, 2'd0, 32'h0, 32'h0000_0012, 1'b1,
              s, a, ty, tg, st, wo, cd, cv);
        chk("R7 byte error ones", cd, 32'hFFFF_FFFF);
        issue(1'b0, 8'd4, 5'd0, 3'd0, 12'h008, 2'd2, 32'h0, 32'h5555_5555, 1'b1,
              s, a, ty, tg, st, wo, cd, cv);
        chk("R7 word error ones", cd, 32'hFFFF_FFFF);
    endtask

    task automatic t_write;
        logic s, cv; logic [31:0] a, tg, wo, cd; logic [4:0] ty; logic [3:0] st;
        issue(1'b1, 8'd0, 5'd0, 3'd0, 12'h023, 2'd0, 32'h1111_115A, 32'h0, 1'b0,
              s, a, ty, tg, st, wo, cd, cv);
        chk("R9 byte strb", {28'b0, st}, 32'h8);
        chk("R9 byte data", wo, 32'h5A00_0000);
        chk("R4 write addr", a, 32'h01FF_C020);
        issue(1'b1, 8'd2, 5'd0, 3'd0, 12'h016, 2'd1, 32'hFFFF_BEEF, 32'h0, 1'b0,
              s, a, ty, tg, st, wo, cd, cv);
        chk("R9 half strb", {28'b0, st}, 32'hC);
        chk("R9 half data", wo, 32'hBEEF_0000);
        issue(1'b1, 8'd1, 5'd0, 3'd0, 12'h00C, 2'd3, 32'hCAFE_F00D, 32'h0, 1'b0,
              s, a, ty, tg, st, wo, cd, cv);
        chk("R9 word strb", {28'b0, st}, 32'hF);
        chk("R9 word data", wo, 32'hCAFE_F00D);
        chk("R9 write cpl", cd, 32'h0);
    endtask

    initial begin
        repeat (20000) @(posedge clk);
        errors++;
        $display("FAIL watchdog actual=hung expected=done");
        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

    initial begin
        repeat (3) @(negedge clk);
        t_reset();
        rst_n = 1'b1;
        @(negedge clk);
        t_reset();
        t_bus0();
        t_bus1();
        t_deep();
        t_filter();
        t_error();
        t_write();
        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end
endmodule